// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital start-up and fault-recovery controller of a voltage-mode switching regulator. It waits until the bias-supply power-good flag and the enable level are both high. It then brings up the oscillator and releases PWM switching while it drives an N-bit soft-start code. This code limits the error-amplifier reference, so the output voltage rises at a controlled rate. When the code reaches full scale, the regulator runs at its final reference. The ramp advances only on a clock-enable tick, so the length of a ramp is set by the tick rate.

An overcurrent flag sampled while switching is allowed stops PWM at once. The block then runs `DELAY_RAMPS` (default three) internal ramps that drive no output, with the oscillator still running. The output ramps again only on the ramp after those. If the fault is still present, the same blanking interval starts again, and this repeats with no limit. If power-good or enable drops, the block returns to idle from any state: the oscillator stops, PWM is blocked and the ramp is re-armed.

Top module: `softstart_hiccup_seq`

## Requirements
- R1: While reset is asserted, and after it until a start condition is seen, `ss_code_o` is 0, `pwm_allow_o` is 0 and `osc_run_o` is 0.
- R2: The block leaves idle only when `por_ok_i` and `enable_i` are both 1. One cycle after that condition is applied, `osc_run_o` and `pwm_allow_o` are 1 and `ss_code_o` is 0. Either input alone starts nothing.
- R3: While ramping, `ss_code_o` rises by exactly one in the cycle after each cycle with `tick_i` high, and holds its value after cycles with `tick_i` low.
- R4: A ramp reaches full scale (2^SS_BITS-1) after 2^SS_BITS-1 ticks. The code then saturates there with PWM allowed, until a fault or a shutdown.
- R5: When `oc_i` is 1 in a cycle where PWM is allowed, the next cycle shows `pwm_allow_o`=0 and `ss_code_o`=0, with `osc_run_o` still 1.
- R6: After a fault, PWM stays blocked and `ss_code_o` stays 0 for exactly DELAY_RAMPS*(2^SS_BITS-1) ticks, and `oc_i` has no effect during that time. The cycle after the last of those ticks starts a normal output ramp from code 0, with PWM allowed.
- R7: If `oc_i` is still high when the retry ramp starts, the block blanks again for the full interval. This fault-and-retry cycle repeats without limit.
- R8: If `por_ok_i` or `enable_i` is 0, the next cycle shows all outputs at 0, from any state. A later start runs a fresh ramp from 0, and a later fault gets the full blanking interval again.
- R9: `oc_i` is acted on during a ramp as well as at full scale. It is ignored while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Ramp timebase clock enable |
| por_ok_i | input | 1 | Bias supply above its power-on threshold |
| enable_i | input | 1 | Regulator enable level |
| oc_i | input | 1 | Sampled overcurrent flag |
| ss_code_o | output | SS_BITS | Soft-start reference code |
| pwm_allow_o | output | 1 | PWM switching permitted |
| osc_run_o | output | 1 | Oscillator run request |

## Verification
All outputs are decoded from registers. Every result is therefore due exactly one clock after the input cycle that causes it: a start, a tick, a fault sample, a shutdown and the final blanking tick all behave this way. The driver applies inputs at the falling edge and pushes the expected output for that cycle into a queue. The monitor pops that entry one nanosecond after the next rising edge, so each comparison lines up with the single register stage. The blanking length is counted in ticks rather than cycles, and the bench gates the tick to prove that the count follows ticks.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_RAMP  = 3'd1,
    SQ_RUN   = 3'd2,
    SQ_BLANK = 3'd3,
    SQ_RETRY = 3'd4
  } sq_state_e;

  function automatic logic sq_drives_output(input sq_state_e s);
    return (s == SQ_RAMP) || (s == SQ_RUN) || (s == SQ_RETRY);
  endfunction

endpackage

// File: rtl/sseq_ramp_ctr.sv
module sseq_ramp_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] code,
  output logic         last
);
  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] PRE  = FULL - {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (clr) begin
      code_d = '0;
    end else if (adv && (code_q != FULL)) begin
      code_d = code_q + {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code = code_q;
  assign last = (code_q == PRE);
endmodule

// File: rtl/sseq_blank_ctr.sv
module sseq_blank_ctr #(
  parameter int RAMPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  generate
    if (RAMPS <= 1) begin : g_single
      assign last = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(RAMPS);
      localparam logic [CW-1:0] TOP = CW'(RAMPS - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign last = (cnt_q == TOP);
    end
  endgenerate
endmodule

// File: rtl/sseq_fsm.sv
module sseq_fsm
  import sseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      oc,
  input  logic      tick,
  input  logic      ramp_last,
  input  logic      blank_last,
  output sq_state_e state,
  output logic      ctr_clr,
  output logic      ctr_adv,
  output logic      blk_clr,
  output logic      blk_inc
);
  sq_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    ctr_clr = 1'b0;
    ctr_adv = 1'b0;
    blk_clr = 1'b0;
    blk_inc = 1'b0;
    if (!go) begin
      st_d    = SQ_IDLE;
      ctr_clr = 1'b1;
      blk_clr = 1'b1;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          st_d    = SQ_RAMP;
          ctr_clr = 1'b1;
          blk_clr = 1'b1;
        end
        SQ_RAMP, SQ_RETRY: begin
          if (oc) begin
            st_d    = SQ_BLANK;
            ctr_clr = 1'b1;
            blk_clr = 1'b1;
          end else if (tick) begin
            ctr_adv = 1'b1;
            if (ramp_last) st_d = SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (oc) begin
            st_d    = SQ_BLANK;
            ctr_clr = 1'b1;
            blk_clr = 1'b1;
          end
        end
        SQ_BLANK: begin
          if (tick) begin
            if (ramp_last) begin
              ctr_clr = 1'b1;
              if (blank_last) begin
                st_d    = SQ_RETRY;
                blk_clr = 1'b1;
              end else begin
                blk_inc = 1'b1;
              end
            end else begin
              ctr_adv = 1'b1;
            end
          end
        end
        default: begin
          st_d    = SQ_IDLE;
          ctr_clr = 1'b1;
          blk_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/softstart_hiccup_seq.sv
module softstart_hiccup_seq
  import sseq_pkg::*;
#(
  parameter int SS_BITS     = 10,
  parameter int DELAY_RAMPS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               por_ok_i,
  input  logic               enable_i,
  input  logic               oc_i,
  output logic [SS_BITS-1:0] ss_code_o,
  output logic               pwm_allow_o,
  output logic               osc_run_o
);
  sq_state_e           state;
  logic                ctr_clr, ctr_adv, blk_clr, blk_inc;
  logic                ramp_last, blank_last;
  logic [SS_BITS-1:0]  code;
  logic                go;

  assign go = por_ok_i & enable_i;

  sseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .oc         (oc_i),
    .tick       (tick_i),
    .ramp_last  (ramp_last),
    .blank_last (blank_last),
    .state      (state),
    .ctr_clr    (ctr_clr),
    .ctr_adv    (ctr_adv),
    .blk_clr    (blk_clr),
    .blk_inc    (blk_inc)
  );

  sseq_ramp_ctr #(.W(SS_BITS)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctr_clr),
    .adv   (ctr_adv),
    .code  (code),
    .last  (ramp_last)
  );

  sseq_blank_ctr #(.RAMPS(DELAY_RAMPS)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (blk_clr),
    .inc   (blk_inc),
    .last  (blank_last)
  );

  assign pwm_allow_o = sq_drives_output(state);
  assign osc_run_o   = (state != SQ_IDLE);
  assign ss_code_o   = pwm_allow_o ? code : '0;
endmodule

// File: rtl/softstart_hiccup_seq_chk.sv
module softstart_hiccup_seq_chk #(
  parameter int SS_BITS     = 10,
  parameter int DELAY_RAMPS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               por_ok_i,
  input logic               enable_i,
  input logic               oc_i,
  input logic [SS_BITS-1:0] ss_code_o,
  input logic               pwm_allow_o,
  input logic               osc_run_o
);
  localparam logic [SS_BITS-1:0] FULL = {SS_BITS{1'b1}};
  localparam int TOTAL = DELAY_RAMPS * ((1 << SS_BITS) - 1);
  localparam int CW    = $clog2(TOTAL + 2);
  localparam logic [CW-1:0] TOTAL_C = CW'(TOTAL);

  logic [CW-1:0] blank_ticks_q;
  logic          blanked;
  assign blanked = osc_run_o & ~pwm_allow_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_ticks_q <= '0;
    end else if (!blanked) begin
      blank_ticks_q <= '0;
    end else if (tick_i && (blank_ticks_q <= TOTAL_C)) begin
      blank_ticks_q <= blank_ticks_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(por_ok_i && enable_i) |=> (!pwm_allow_o && !osc_run_o && ss_code_o == '0)); // R8

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_allow_o && ss_code_o != FULL && !oc_i && por_ok_i && enable_i)
    |=> (ss_code_o == $past(ss_code_o) + {{(SS_BITS-1){1'b0}}, $past(tick_i)})); // R3

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_allow_o && ss_code_o == FULL && !oc_i && por_ok_i && enable_i)
    |=> (pwm_allow_o && ss_code_o == FULL)); // R4

  AST_OC_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_allow_o && oc_i && por_ok_i && enable_i)
    |=> (!pwm_allow_o && osc_run_o && ss_code_o == '0)); // R5

  AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    blanked |-> (blank_ticks_q <= TOTAL_C && ss_code_o == '0)); // R6

  AST_RETRY_AFTER_FULL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_allow_o && $past(blanked)) |-> (blank_ticks_q == TOTAL_C && ss_code_o == '0)); // R6

  AST_PWM_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_allow_o |-> osc_run_o); // R2

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!pwm_allow_o && !osc_run_o && ss_code_o == '0); // R1
    end
  end
endmodule

bind softstart_hiccup_seq softstart_hiccup_seq_chk #(
  .SS_BITS     (SS_BITS),
  .DELAY_RAMPS (DELAY_RAMPS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .por_ok_i    (por_ok_i),
  .enable_i    (enable_i),
  .oc_i        (oc_i),
  .ss_code_o   (ss_code_o),
  .pwm_allow_o (pwm_allow_o),
  .osc_run_o   (osc_run_o)
);

// File: tb/softstart_hiccup_seq_bench.sv
`timescale 1ns/1ps
module softstart_hiccup_seq_bench;
  localparam int W     = 4;
  localparam int NR    = 3;
  localparam int FULLV = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         tick_i, por_ok_i, enable_i, oc_i;
  logic [W-1:0] ss_code_o;
  logic         pwm_allow_o, osc_run_o;

  softstart_hiccup_seq #(.SS_BITS(W), .DELAY_RAMPS(NR)) u_softstart_hiccup_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .por_ok_i    (por_ok_i),
    .enable_i    (enable_i),
    .oc_i        (oc_i),
    .ss_code_o   (ss_code_o),
    .pwm_allow_o (pwm_allow_o),
    .osc_run_o   (osc_run_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int    code;
    bit    pwm;
    bit    osc;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    n_vec  = 0;
  int    n_miss = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Expected behaviour, phases: 0 idle, 1 ramp, 2 full scale, 3 blanked, 4 retry ramp
  int m_mode = 0;
  int m_t    = 0;
  int m_k    = 0;

  task automatic cyc(input bit p, input bit e, input bit o, input bit t);
    exp_t x;
    @(negedge clk);
    por_ok_i = p; enable_i = e; oc_i = o; tick_i = t;
    if (!(p && e)) begin
      m_mode = 0; m_t = 0; m_k = 0;
    end else begin
      case (m_mode)
        0: begin m_mode = 1; m_t = 0; end
        1, 4: begin
          if (o) begin m_mode = 3; m_t = 0; m_k = 0; end
          else if (t) begin
            m_t++;
            if (m_t == FULLV) m_mode = 2;
          end
        end
        2: if (o) begin m_mode = 3; m_t = 0; m_k = 0; end
        default: if (t) begin
          m_t++;
          if (m_t == FULLV) begin
            m_t = 0; m_k++;
            if (m_k == NR) begin m_mode = 4; m_k = 0; end
          end
        end
      endcase
    end
    x.pwm  = (m_mode == 1) || (m_mode == 2) || (m_mode == 4);
    x.osc  = (m_mode != 0);
    x.code = (m_mode == 2) ? FULLV : (x.pwm ? m_t : 0);
    x.req  = cur_req;
    sb_q.push_back(x);
  endtask

  task automatic run(input int n, input bit p, input bit e, input bit o, input int every);
    for (int i = 0; i < n; i++) cyc(p, e, o, (i % every) == 0);
  endtask

  // Monitor: one result is due one cycle after each driven cycle
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t x;
      x = sb_q.pop_front();
      n_vec++;
      if (int'(ss_code_o) != x.code || pwm_allow_o != x.pwm || osc_run_o != x.osc) begin
        n_miss++;
        $display("FAIL %s: code=%0d pwm=%0b osc=%0b expected code=%0d pwm=%0b osc=%0b at %0t",
                 x.req, ss_code_o, pwm_allow_o, osc_run_o, x.code, x.pwm, x.osc, $time);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_ok_i = 1'b1; enable_i = 1'b1; oc_i = 1'b0; tick_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (ss_code_o != '0 || pwm_allow_o || osc_run_o) begin
      n_miss++;
      $display("FAIL R1: code=%0d pwm=%0b osc=%0b expected 0 0 0 in reset", ss_code_o, pwm_allow_o, osc_run_o);
    end
    @(negedge clk);
    por_ok_i = 1'b0; enable_i = 1'b0;
    rst_n = 1'b1;
    cur_req = "R1"; run(3, 0, 0, 0, 1);
    cur_req = "R2"; run(4, 1, 0, 0, 1);
    run(4, 0, 1, 0, 1);
    cur_req = "R9"; run(3, 0, 1, 1, 1);       // overcurrent while idle ignored
    cur_req = "R2"; run(1, 1, 1, 0, 1);       // start
    cur_req = "R3"; run(20, 1, 1, 0, 3);      // gated ticks
    cur_req = "R4"; run(25, 1, 1, 0, 1);      // reach and hold full scale
    cur_req = "R5"; run(1, 1, 1, 1, 1);       // fault at full scale
    cur_req = "R6"; run(10, 1, 1, 1, 1);      // oc ignored while blanked
    run(120, 1, 1, 0, 2);                     // rest of delay, retry, full scale
    cur_req = "R7"; run(110, 1, 1, 1, 1);     // persistent fault: repeated hiccup
    cur_req = "R6"; run(70, 1, 1, 0, 1);
    cur_req = "R8"; run(1, 1, 0, 0, 1);
    run(1, 1, 1, 0, 1);
    cur_req = "R9"; run(5, 1, 1, 0, 1);
    run(1, 1, 1, 1, 1);                       // fault mid-ramp
    cur_req = "R8"; run(10, 1, 1, 0, 1);
    run(2, 1, 0, 0, 1);                       // shutdown during blanking
    run(20, 1, 1, 0, 1);                      // fresh ramp
    run(1, 1, 1, 1, 1);
    run(60, 1, 1, 0, 1);                      // full delay again
    run(2, 0, 1, 0, 1);                       // power-good loss at full scale
    run(5, 1, 1, 0, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule